// File: doc/BRIEF.md
# SPI Status and Request Router

This block keeps the event flags of a FIFO-based SPI controller and turns them into service requests. The shifter reports frame completion, end of a command queue, transmit underrun and receive overrun as one-cycle pulses. The FIFOs report "transmit FIFO has room" and "receive FIFO holds data" as levels. Each event is held as a status flag. Software reads the flags through a small register port and clears sticky flags by writing ones.

Each flag has its own request enable. Every enabled flag that is set feeds one interrupt line. The transmit-room flag and the receive-data flag each have a route-select bit. With the select and the enable both set, that flag drives its own DMA request line and no longer reaches the interrupt. A flag therefore reaches either the interrupt or a DMA line, never both.

A halt bit and a module-disable bit together give a read-only running status. Reset leaves the block halted with every flag and enable cleared. All three request outputs are registered.

Top module: `spi_status_router`

Register map (address: contents):
- 0: status, read, write 1 to clear. Bit 0 frame done, bit 1 queue end, bit 2 TX underrun, bit 3 TX room, bit 4 RX overrun, bit 5 RX data, bit 7 running.
- 1: request enables, same bit positions 0 to 5.
- 2: route selects, bit 0 TX room to DMA, bit 1 RX data to DMA.
- 3: control, bit 0 halt, bit 1 disable.

## Requirements
- R1: After reset:
  - status reads 0x00, enables read 0x00, route selects read 0x00 and control reads 0x01 (halt set);
  - irq, tx_dma_req and rx_dma_req are low.
- R2: A pulse on a frame-done, queue-end, TX-underrun or RX-overrun input sets status bit 0, 1, 2 or 4 in turn, and the bit stays set until it is cleared.
- R3: Writing address 0 clears each sticky flag whose data bit is 1; a bit written 0 leaves its flag unchanged.
- R4: If an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends set.
- R5: irq is the OR of the set flags whose enable bit at address 1 is 1, leaving out a flag routed to DMA; a set flag whose enable is 0 never raises irq.
- R6: Status bit 3 follows tx_has_room and bit 5 follows rx_has_data, one cycle later; writing 1 to these bits has no effect.
- R7: With enable bit 3 set, route bit 0 set moves the TX-room flag onto tx_dma_req and off irq; route bit 0 clear sends it to irq with tx_dma_req low.
- R8: With enable bit 5 set, route bit 1 set moves the RX-data flag onto rx_dma_req and off irq; route bit 1 clear sends it to irq with rx_dma_req low.
- R9: A route bit set while its enable is 0 gives no DMA request and no interrupt.
- R10: Status bit 7 (running) is 1 only when halt and disable are both 0. It shows on a status read two cycles after the control write.
- R11: irq, tx_dma_req and rx_dma_req are registered and change one cycle after the flag that drives them; a DMA request drops two cycles after its FIFO level input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_frame_done | input | 1 | Pulse: a frame has finished shifting |
| ev_queue_end | input | 1 | Pulse: the last queued command finished |
| ev_tx_underrun | input | 1 | Pulse: a shift started with the TX FIFO empty |
| tx_has_room | input | 1 | Level: TX FIFO is not full |
| ev_rx_overrun | input | 1 | Pulse: a frame arrived with the RX FIFO full |
| rx_has_data | input | 1 | Level: RX FIFO is not empty |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address; read data is registered from it every cycle |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | TX DMA request (level) |
| rx_dma_req | output | 1 | RX DMA request (level) |

## Verification
Each pulse event is raised on its own and also two at a time. This shows that each input lands on its own status bit and that unrelated bits stay clear. Clears are written three ways:
- with zero bits, which must change nothing;
- as exact masks;
- in the same cycle as a new event, which shows whether set wins.

The enable and route registers are swept over four settings for each FIFO-level flag: interrupt only, DMA only, route without enable, and disabled. Together these tell a routing fault from an enable fault. The falling edge of a FIFO level is sampled one cycle and two cycles after the drop to pin the output latency. The halt and disable bits are toggled one at a time to show that each alone stops the running status.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int NUM_FLAGS = 6;

  localparam int FLG_DONE  = 0;
  localparam int FLG_QEND  = 1;
  localparam int FLG_TXUR  = 2;
  localparam int FLG_ROOM  = 3;
  localparam int FLG_RXOR  = 4;
  localparam int FLG_DATA  = 5;
  localparam int RUN_BIT   = 7;

  // flags that mirror a FIFO level instead of latching a pulse
  localparam logic [NUM_FLAGS-1:0] LEVEL_MASK = (1 << FLG_ROOM) | (1 << FLG_DATA);

  localparam int ADR_STATUS = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_ROUTE  = 2;
  localparam int ADR_CTRL   = 3;

  localparam int RT_TX = 0;
  localparam int RT_RX = 1;
  localparam int CT_HALT = 0;
  localparam int CT_DIS  = 1;
endpackage

// File: rtl/spi_sr_flag_bank.sv
module spi_sr_flag_bank
  import spi_sr_pkg::*;
#(
  parameter int N = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    if (LEVEL_MASK[i]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) flags[i] <= 1'b0;
        else     flags[i] <= ev[i];
      end

      assert_level_up_R6: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> flags[i]);
      assert_level_down_R6: assert property (@(posedge clk) disable iff (rst)
        !ev[i] |=> !flags[i]);
    end else begin : g_sticky
      logic hit;
      assign hit = clr_we & clr_mask[i];
      always_ff @(posedge clk) begin
        if (rst)        flags[i] <= 1'b0;
        else if (ev[i]) flags[i] <= 1'b1;
        else if (hit)   flags[i] <= 1'b0;
      end

      assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> flags[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (flags[i] && !hit) |=> flags[i]);
      assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && !ev[i]) |=> !flags[i]);
    end
  end
endmodule

// File: rtl/spi_sr_ctrl_regs.sv
module spi_sr_ctrl_regs
  import spi_sr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int N      = NUM_FLAGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [N-1:0]      req_en,
  output logic              tx_route,
  output logic              rx_route,
  output logic              halt,
  output logic              mod_dis,
  output logic              running
);
  logic wr_en, wr_rt, wr_ct;
  assign wr_en = reg_wr && (reg_addr == ADDR_W'(ADR_ENABLE));
  assign wr_rt = reg_wr && (reg_addr == ADDR_W'(ADR_ROUTE));
  assign wr_ct = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_en   <= '0;
      tx_route <= 1'b0;
      rx_route <= 1'b0;
      halt     <= 1'b1;
      mod_dis  <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (wr_en) req_en <= reg_wdata[N-1:0];
      if (wr_rt) begin
        tx_route <= reg_wdata[RT_TX];
        rx_route <= reg_wdata[RT_RX];
      end
      if (wr_ct) begin
        halt    <= reg_wdata[CT_HALT];
        mod_dis <= reg_wdata[CT_DIS];
      end
      running <= !halt && !mod_dis;
    end
  end

  assert_run_needs_go_R10: assert property (@(posedge clk) disable iff (rst)
    running |-> (!$past(halt) && !$past(mod_dis)));
endmodule

// File: rtl/spi_sr_router.sv
module spi_sr_router
  import spi_sr_pkg::*;
#(
  parameter int N = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] req_en,
  input  logic         tx_route,
  input  logic         rx_route,
  output logic         irq,
  output logic         tx_dma_req,
  output logic         rx_dma_req
);
  logic         tx_to_dma, rx_to_dma;
  logic [N-1:0] dma_mask, irq_src;

  assign tx_to_dma = req_en[FLG_ROOM] & tx_route;
  assign rx_to_dma = req_en[FLG_DATA] & rx_route;

  always_comb begin
    dma_mask = '0;
    dma_mask[FLG_ROOM] = tx_to_dma;
    dma_mask[FLG_DATA] = rx_to_dma;
    irq_src = flags & req_en & ~dma_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      irq        <= |irq_src;
      tx_dma_req <= tx_to_dma & flags[FLG_ROOM];
      rx_dma_req <= rx_to_dma & flags[FLG_DATA];
    end
  end

  assert_irq_off_when_masked_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(|req_en) |-> !irq);
  assert_tx_route_R7: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> $past(tx_route));
  assert_rx_route_R8: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> $past(rx_route));
  assert_dma_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_dma_req |-> $past(req_en[FLG_ROOM])) and (rx_dma_req |-> $past(req_en[FLG_DATA])));
  assert_dma_latency_R11: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> $past(flags[FLG_ROOM]));
endmodule

// File: rtl/spi_status_router.sv
module spi_status_router
  import spi_sr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_frame_done,
  input  logic              ev_queue_end,
  input  logic              ev_tx_underrun,
  input  logic              tx_has_room,
  input  logic              ev_rx_overrun,
  input  logic              rx_has_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  localparam int N = NUM_FLAGS;

  logic [N-1:0] ev_vec, flags, req_en;
  logic         tx_route, rx_route, halt, mod_dis, running;
  logic         clr_we;

  always_comb begin
    ev_vec = '0;
    ev_vec[FLG_DONE] = ev_frame_done;
    ev_vec[FLG_QEND] = ev_queue_end;
    ev_vec[FLG_TXUR] = ev_tx_underrun;
    ev_vec[FLG_ROOM] = tx_has_room;
    ev_vec[FLG_RXOR] = ev_rx_overrun;
    ev_vec[FLG_DATA] = rx_has_data;
  end

  assign clr_we = reg_wr && (reg_addr == ADDR_W'(ADR_STATUS));

  spi_sr_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .ev(ev_vec), .clr_we(clr_we),
    .clr_mask(reg_wdata[N-1:0]), .flags(flags)
  );

  spi_sr_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N)) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_en(req_en), .tx_route(tx_route),
    .rx_route(rx_route), .halt(halt), .mod_dis(mod_dis), .running(running)
  );

  spi_sr_router #(.N(N)) u_route (
    .clk(clk), .rst(rst), .flags(flags), .req_en(req_en),
    .tx_route(tx_route), .rx_route(rx_route), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_W'(ADR_STATUS): begin
        rd_next[N-1:0]   = flags;
        rd_next[RUN_BIT] = running;
      end
      ADDR_W'(ADR_ENABLE): rd_next[N-1:0] = req_en;
      ADDR_W'(ADR_ROUTE): begin
        rd_next[RT_TX] = tx_route;
        rd_next[RT_RX] = rx_route;
      end
      ADDR_W'(ADR_CTRL): begin
        rd_next[CT_HALT] = halt;
        rd_next[CT_DIS]  = mod_dis;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !tx_dma_req && !rx_dma_req));
endmodule

// File: tb/spi_status_router_tb.sv
module spi_status_router_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_frame_done = 0, ev_queue_end = 0, ev_tx_underrun = 0;
  logic       tx_has_room = 0, ev_rx_overrun = 0, rx_has_data = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq, tx_dma_req, rx_dma_req;

  always #2 clk = ~clk;

  spi_status_router u_dut (
    .clk(clk), .rst(rst), .ev_frame_done(ev_frame_done), .ev_queue_end(ev_queue_end),
    .ev_tx_underrun(ev_tx_underrun), .tx_has_room(tx_has_room),
    .ev_rx_overrun(ev_rx_overrun), .rx_has_data(rx_has_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  typedef struct {int cyc; int sel; int exp; string tag;} item_t;
  item_t sb[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the items due in this cycle and compares them
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.sel)
        0: act = int'(reg_rdata);
        1: act = int'(irq);
        2: act = int'(tx_dma_req);
        default: act = int'(rx_dma_req);
      endcase
      checks++;
      if (it.cyc != cyc || act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h (due %0d at %0d)",
                 it.tag, it.sel, act, it.exp, it.cyc, cyc);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int sel, int dcyc, int val, string tag);
    item_t it;
    it.cyc = cyc + dcyc; it.sel = sel; it.exp = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(int a, int val, string tag);
    reg_addr = 2'(a);
    expect_at(0, 1, val, tag);
    tick();
  endtask

  task automatic pulse(logic [3:0] m); // {rxor, txur, qend, done}
    {ev_rx_overrun, ev_tx_underrun, ev_queue_end, ev_frame_done} = m;
    tick();
    {ev_rx_overrun, ev_tx_underrun, ev_queue_end, ev_frame_done} = 4'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    rd(0, 8'h00, "R1 status");
    rd(1, 8'h00, "R1 enables");
    rd(2, 8'h00, "R1 routes");
    rd(3, 8'h01, "R1 control");
    expect_at(1, 1, 0, "R1 irq");
    expect_at(2, 1, 0, "R1 txdma");
    expect_at(3, 1, 0, "R1 rxdma");
    tick();

    // R2 sticky set, no enable -> no irq
    pulse(4'b0001);
    tick();
    rd(0, 8'h01, "R2 frame done");
    expect_at(1, 1, 0, "R5 disabled flag");
    tick();
    wr(1, 8'h01);
    expect_at(1, 1, 1, "R5 enabled flag");
    tick();

    // R3 write zero no effect, write one clears
    wr(0, 8'h00);
    tick();
    rd(0, 8'h01, "R3 write 0 keeps");
    wr(0, 8'h01);
    expect_at(1, 1, 0, "R11 irq drops after clear");
    tick();
    rd(0, 8'h00, "R3 write 1 clears");

    // R2 two events together
    pulse(4'b1010);
    tick();
    rd(0, 8'h12, "R2 qend and rxor");

    // R4 set wins over clear
    ev_queue_end = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h02;
    tick();
    ev_queue_end = 0; reg_wr = 0;
    tick();
    rd(0, 8'h12, "R4 set wins");
    wr(0, 8'h12);
    tick();
    rd(0, 8'h00, "R3 mask clear");

    // R5 only enabled flags reach irq
    wr(1, 8'h04);
    pulse(4'b0100);
    expect_at(1, 1, 1, "R11 irq one cycle after flag");
    tick();
    pulse(4'b0001);
    wr(0, 8'h04);
    expect_at(1, 1, 0, "R5 disabled done flag blocked");
    tick(); tick();
    wr(0, 8'h01);
    wr(1, 8'h00);
    tick();

    // R6 level flags
    tx_has_room = 1;
    tick(); tick();
    rd(0, 8'h08, "R6 room follows level");
    wr(0, 8'h08);
    tick();
    rd(0, 8'h08, "R6 write 1 no effect");
    tx_has_room = 0;
    tick(); tick();
    rd(0, 8'h00, "R6 room drops");

    // R7 tx routing
    tx_has_room = 1;
    wr(1, 8'h08);
    tick(); tick();
    expect_at(1, 1, 1, "R7 room to irq");
    expect_at(2, 1, 0, "R7 no txdma when routed to irq");
    tick();
    wr(2, 8'h01);
    tick();
    expect_at(1, 1, 0, "R7 room off irq");
    expect_at(2, 1, 1, "R7 txdma");
    tick();
    tx_has_room = 0;
    expect_at(2, 1, 1, "R11 txdma still high");
    expect_at(2, 2, 0, "R11 txdma drops");
    tick(); tick(); tick();

    // R8 rx routing
    wr(1, 8'h20);
    wr(2, 8'h02);
    rx_has_data = 1;
    tick(); tick();
    expect_at(3, 1, 1, "R8 rxdma");
    expect_at(1, 1, 0, "R8 data off irq");
    tick();
    wr(2, 8'h00);
    tick();
    expect_at(1, 1, 1, "R8 data to irq");
    expect_at(3, 1, 0, "R8 no rxdma");
    tick();
    rx_has_data = 0;
    tick(); tick();

    // R9 route without enable
    wr(1, 8'h00);
    wr(2, 8'h03);
    tx_has_room = 1; rx_has_data = 1;
    tick(); tick();
    expect_at(1, 1, 0, "R9 irq");
    expect_at(2, 1, 0, "R9 txdma");
    expect_at(3, 1, 0, "R9 rxdma");
    tick();
    rd(0, 8'h28, "R6 both levels");
    tx_has_room = 0; rx_has_data = 0;
    tick(); tick();

    // R10 running status
    rd(0, 8'h00, "R10 halted");
    wr(3, 8'h00);
    tick(); tick();
    rd(0, 8'h80, "R10 running");
    wr(3, 8'h02);
    tick(); tick();
    rd(0, 8'h00, "R10 disabled stops");
    wr(3, 8'h00);
    tick(); tick();
    rd(0, 8'h80, "R10 running again");
    wr(3, 8'h01);
    tick(); tick();
    rd(0, 8'h00, "R10 halt stops");

    tick(); tick(); tick();
    if (sb.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard left %0d items", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule